// File: doc/BRIEF.md
# Parameter Page Validator for Raw NAND Start-Up

This block inspects the 256-byte parameter page that a raw NAND device returns during start-up, one byte per accepted beat, as the bytes come off the data bus. While the page streams in, it checks the four-byte ASCII signature at the head of the page. It also runs a 16-bit CRC over the leading 254 bytes and picks out the geometry and error-correction fields that the boot flow needs to set up the controller.

A start strobe that arrives with a valid byte marks that byte as byte 0 of a new page. After the 256th byte, the block raises a done level and presents three flags: signature good, CRC good, and page good. It also presents the computed and stored CRC values and the captured fields. Everything stays stable until the next start strobe. No back-pressure is offered. The source may leave idle cycles between bytes.

Top module: `onfi_param_checker`

## Requirements
- R1: After reset, `done`, `sig_ok`, `crc_ok`, `page_ok` and `ecc_present` are all 0.
- R2: A byte presented with `byte_vld`=1 and `sop`=1 is taken as byte 0 of a new page, even in the middle of a page. A start strobe with `byte_vld`=0 has no effect.
- R3: Bytes with `byte_vld`=0, bytes presented before the first start strobe, and bytes presented after byte 255 (without a new start) change no output.
- R4: `done` goes to 1 in the cycle after byte 255 is accepted. It stays 1 until a new start byte is accepted, which clears it in the following cycle. `done` is 0 while bytes 0 to 255 are arriving.
- R5: `crc_calc` holds a CRC-16 over bytes 0 to 253 only. The polynomial is 0x8005 and the seed is 0x4F4E. Each byte is shifted in MSB first with no reflection: the feedback bit is crc[15] XOR the data bit, the register shifts left, and 0x8005 is XORed in when the feedback bit is 1.
- R6: `crc_stored` is byte 254 (low) and byte 255 (high). `crc_ok` is 1 when `done`=1 and `crc_calc` equals `crc_stored`.
- R7: `sig_ok` is 1 when `done`=1 and bytes 0 to 3 are 4Fh, 4Eh, 46h, 49h.
- R8: `page_ok` is 1 exactly when `sig_ok` and `crc_ok` are both 1.
- R9: `bus16` is bit 0 of byte 6. A 1 means a 16-bit data bus; a 0 means 8 bits.
- R10: `page_bytes`, `blk_pages` and `lun_blocks` are little-endian 32-bit values taken from bytes 80–83, 92–95 and 96–99. `lun_cnt` is byte 100.
- R11: When byte 112 is FFh, `ecc_present`=0, `ecc_bits`=0 and `ecc_step`=0. When it holds any other value, `ecc_present`=1, `ecc_bits` equals that byte and `ecc_step`=512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sop | input | 1 | Start of page, qualified by byte_vld |
| byte_vld | input | 1 | Byte strobe |
| byte_in | input | 8 | Page byte |
| done | output | 1 | Full page received; results valid |
| sig_ok | output | 1 | Signature matched |
| crc_ok | output | 1 | CRC matched |
| page_ok | output | 1 | Signature and CRC both good |
| crc_calc | output | 16 | CRC over bytes 0–253 |
| crc_stored | output | 16 | CRC field from bytes 254–255 |
| bus16 | output | 1 | 16-bit data bus reported |
| page_bytes | output | 32 | Data bytes per page |
| blk_pages | output | 32 | Pages per block |
| lun_blocks | output | 32 | Blocks per LUN |
| lun_cnt | output | 8 | Number of LUNs |
| ecc_present | output | 1 | ECC requirement reported |
| ecc_bits | output | 8 | Correctable bits per step |
| ecc_step | output | 10 | ECC step size in bytes |

## Verification
If the byte index drifts, `done` appears one or more cycles away from the cycle after byte 255, and that is seen at once. A drifted index also moves every captured field onto the wrong bytes, which shows in `page_bytes` and the other fields. A corrupted CRC register or seed shows only at the end of the page, as a wrong `crc_calc` and a cleared `crc_ok` on a page whose stored CRC is correct. A signature flag that is not re-armed at the start strobe shows as a wrong `sig_ok` on the page that follows a bad one.

// File: rtl/onfi_chk_pkg.sv
package onfi_chk_pkg;
  localparam int PAGE_LEN   = 256;
  localparam int IDX_W      = $clog2(PAGE_LEN);
  localparam int CRC_SPAN   = PAGE_LEN - 2;
  localparam int CRC_LO_AT  = CRC_SPAN;
  localparam int CRC_HI_AT  = CRC_SPAN + 1;
  localparam int SIG_LEN    = 4;
  localparam int FEAT_AT    = 6;
  localparam int PGSZ_AT    = 80;
  localparam int PPB_AT     = 92;
  localparam int BPL_AT     = 96;
  localparam int LUNS_AT    = 100;
  localparam int ECC_AT     = 112;
  localparam logic [15:0] CRC_SEED  = 16'h4F4E;
  localparam logic [15:0] CRC_POLY  = 16'h8005;
  localparam logic [7:0]  ECC_NONE  = 8'hFF;
  localparam logic [9:0]  ECC_CHUNK = 10'd512;

  // Expected signature character at position i.
  function automatic logic [7:0] sig_char(input int unsigned i);
    case (i)
      0:       sig_char = 8'h4F;
      1:       sig_char = 8'h4E;
      2:       sig_char = 8'h46;
      default: sig_char = 8'h49;
    endcase
  endfunction

  // One byte of CRC, MSB first, eight unrolled bit steps.
  function automatic logic [15:0] crc_byte(input logic [15:0] c_in,
                                           input logic [7:0]  d,
                                           input logic [15:0] poly);
    logic [15:0] r;
    r = c_in;
    for (int k = 7; k >= 0; k--) begin
      logic fb;
      fb = r[15] ^ d[k];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ poly;
    end
    return r;
  endfunction

  // Drop a byte into a 32-bit little-endian word when idx is inside it.
  function automatic logic [31:0] le_put(input logic [31:0] w,
                                         input int unsigned idx,
                                         input int unsigned base,
                                         input logic [7:0]  d);
    logic [31:0] r;
    r = w;
    for (int k = 0; k < 4; k++) begin
      if (idx == base + k) r[8*k +: 8] = d;
    end
    return r;
  endfunction
endpackage

// File: rtl/onfi_byte_track.sv
module onfi_byte_track
  import onfi_chk_pkg::*;
#(
  parameter int LEN = PAGE_LEN,
  localparam int IW = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sop,
  input  logic          byte_vld,
  output logic          start,
  output logic          accept,
  output logic [IW-1:0] cur_idx,
  output logic          last_hit,
  output logic          done
);
  localparam logic [IW-1:0] LAST = IW'(LEN - 1);

  logic          armed;
  logic [IW-1:0] idx_q;

  assign start    = sop & byte_vld;
  assign accept   = byte_vld & (start | armed);
  assign cur_idx  = start ? '0 : idx_q;
  assign last_hit = accept & (cur_idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      done  <= 1'b0;
      idx_q <= '0;
    end else if (accept) begin
      if (cur_idx == LAST) begin
        armed <= 1'b0;
        done  <= 1'b1;
        idx_q <= '0;
      end else begin
        armed <= 1'b1;
        done  <= 1'b0;
        idx_q <= cur_idx + 1'b1;
      end
    end
  end

  // R4: results appear the cycle after the final byte
  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    last_hit |=> done);
  // R4: done only drops on a new start
  assert_done_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);
  // R2: collection and completion are exclusive phases
  assert_phase_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed, done}));
endmodule

// File: rtl/onfi_crc_acc.sv
module onfi_crc_acc
  import onfi_chk_pkg::*;
#(
  parameter logic [15:0] SEED = CRC_SEED,
  parameter logic [15:0] POLY = CRC_POLY,
  parameter int          SPAN = CRC_SPAN,
  parameter int          IW   = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          accept,
  input  logic [IW-1:0] cur_idx,
  input  logic [7:0]    byte_in,
  output logic [15:0]   crc_calc,
  output logic [15:0]   crc_stored,
  output logic          crc_match
);
  logic [15:0] crc_q;
  logic [15:0] stored_q;
  logic [15:0] crc_base;
  logic        in_span;

  assign in_span  = int'(cur_idx) < SPAN;
  assign crc_base = start ? SEED : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q    <= SEED;
      stored_q <= '0;
    end else if (accept) begin
      if (start) stored_q <= '0;
      if (in_span) crc_q <= crc_byte(crc_base, byte_in, POLY);
      if (int'(cur_idx) == SPAN)     stored_q[7:0]  <= byte_in;
      if (int'(cur_idx) == SPAN + 1) stored_q[15:8] <= byte_in;
    end
  end

  assign crc_calc   = crc_q;
  assign crc_stored = stored_q;
  assign crc_match  = (crc_q == stored_q);

  // R3: the running CRC moves only on accepted bytes
  assert_crc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(crc_q));
  // R5: trailer bytes never enter the CRC
  assert_crc_span_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !in_span) |=> $stable(crc_q));
endmodule

// File: rtl/onfi_field_grab.sv
module onfi_field_grab
  import onfi_chk_pkg::*;
#(
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          accept,
  input  logic [IW-1:0] cur_idx,
  input  logic [7:0]    byte_in,
  output logic          sig_good,
  output logic          bus16,
  output logic [31:0]   page_bytes,
  output logic [31:0]   blk_pages,
  output logic [31:0]   lun_blocks,
  output logic [7:0]    lun_cnt,
  output logic [7:0]    ecc_raw
);
  int unsigned ix;
  assign ix = int'(cur_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_good   <= 1'b0;
      bus16      <= 1'b0;
      page_bytes <= '0;
      blk_pages  <= '0;
      lun_blocks <= '0;
      lun_cnt    <= '0;
      ecc_raw    <= ECC_NONE;
    end else if (accept) begin
      if (start) begin
        sig_good   <= (byte_in == sig_char(0));
        bus16      <= 1'b0;
        page_bytes <= '0;
        blk_pages  <= '0;
        lun_blocks <= '0;
        lun_cnt    <= '0;
        ecc_raw    <= ECC_NONE;
      end else begin
        if (ix < SIG_LEN && byte_in != sig_char(ix)) sig_good <= 1'b0;
        if (ix == FEAT_AT) bus16   <= byte_in[0];
        if (ix == LUNS_AT) lun_cnt <= byte_in;
        if (ix == ECC_AT)  ecc_raw <= byte_in;
        page_bytes <= le_put(page_bytes, ix, PGSZ_AT, byte_in);
        blk_pages  <= le_put(blk_pages,  ix, PPB_AT,  byte_in);
        lun_blocks <= le_put(lun_blocks, ix, BPL_AT,  byte_in);
      end
    end
  end

  // R3: captured geometry is frozen between accepted bytes
  assert_fields_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> ($stable(page_bytes) && $stable(lun_cnt) && $stable(ecc_raw)));
  // R7: a signature mismatch is never undone within the page
  assert_sig_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sig_good && !start) |=> !sig_good);
endmodule

// File: rtl/onfi_param_checker.sv
module onfi_param_checker
  import onfi_chk_pkg::*;
#(
  parameter logic [15:0] SEED = CRC_SEED,
  parameter logic [15:0] POLY = CRC_POLY
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sop,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic        done,
  output logic        sig_ok,
  output logic        crc_ok,
  output logic        page_ok,
  output logic [15:0] crc_calc,
  output logic [15:0] crc_stored,
  output logic        bus16,
  output logic [31:0] page_bytes,
  output logic [31:0] blk_pages,
  output logic [31:0] lun_blocks,
  output logic [7:0]  lun_cnt,
  output logic        ecc_present,
  output logic [7:0]  ecc_bits,
  output logic [9:0]  ecc_step
);
  logic             start;
  logic             accept;
  logic [IDX_W-1:0] cur_idx;
  logic             last_hit;
  logic             crc_match;
  logic             sig_good;
  logic [7:0]       ecc_raw;

  onfi_byte_track #(.LEN(PAGE_LEN)) u_track (
    .clk(clk), .rst_n(rst_n), .sop(sop), .byte_vld(byte_vld),
    .start(start), .accept(accept), .cur_idx(cur_idx),
    .last_hit(last_hit), .done(done)
  );

  onfi_crc_acc #(.SEED(SEED), .POLY(POLY), .SPAN(CRC_SPAN), .IW(IDX_W)) u_crc (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .cur_idx(cur_idx), .byte_in(byte_in),
    .crc_calc(crc_calc), .crc_stored(crc_stored), .crc_match(crc_match)
  );

  onfi_field_grab #(.IW(IDX_W)) u_grab (
    .clk(clk), .rst_n(rst_n), .start(start), .accept(accept),
    .cur_idx(cur_idx), .byte_in(byte_in),
    .sig_good(sig_good), .bus16(bus16), .page_bytes(page_bytes),
    .blk_pages(blk_pages), .lun_blocks(lun_blocks), .lun_cnt(lun_cnt),
    .ecc_raw(ecc_raw)
  );

  assign sig_ok      = done & sig_good;
  assign crc_ok      = done & crc_match;
  assign page_ok     = sig_ok & crc_ok;
  assign ecc_present = (ecc_raw != ECC_NONE);
  assign ecc_bits    = ecc_present ? ecc_raw : 8'h00;
  assign ecc_step    = ecc_present ? ECC_CHUNK : 10'd0;

  // R3: a finished result is not disturbed by stray bytes
  assert_result_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> ($stable(crc_calc) && $stable(crc_stored) && $stable(page_ok)));
  // R8: a good page is never flagged before completion
  assert_ok_needs_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    page_ok |-> done);
endmodule

// File: tb/onfi_param_checker_test.sv
module onfi_param_checker_test;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sop = 1'b0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_in = 8'h00;
  logic        done, sig_ok, crc_ok, page_ok, bus16, ecc_present;
  logic [15:0] crc_calc, crc_stored;
  logic [31:0] page_bytes, blk_pages, lun_blocks;
  logic [7:0]  lun_cnt, ecc_bits;
  logic [9:0]  ecc_step;

  int total = 0;
  int bad = 0;
  logic [7:0]  pg [256];
  logic [15:0] exp_crc;

  always #(CLK_NS/2) clk = ~clk;

  onfi_param_checker uut (
    .clk(clk), .rst_n(rst_n), .sop(sop), .byte_vld(byte_vld), .byte_in(byte_in),
    .done(done), .sig_ok(sig_ok), .crc_ok(crc_ok), .page_ok(page_ok),
    .crc_calc(crc_calc), .crc_stored(crc_stored), .bus16(bus16),
    .page_bytes(page_bytes), .blk_pages(blk_pages), .lun_blocks(lun_blocks),
    .lun_cnt(lun_cnt), .ecc_present(ecc_present), .ecc_bits(ecc_bits),
    .ecc_step(ecc_step)
  );

  // {sig_bad, crc_bad, gaps, feat[7:0], ecc[7:0], luns[7:0], page_bytes[31:0]}
  localparam int NV = 5;
  localparam logic [58:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 8'h01, 8'h04, 8'h01, 32'h0000_0800},
    {1'b0, 1'b0, 1'b1, 8'h00, 8'hFF, 8'h02, 32'h0000_1000},
    {1'b1, 1'b0, 1'b0, 8'h03, 8'h08, 8'h04, 32'h0000_0200},
    {1'b0, 1'b1, 1'b0, 8'h02, 8'h00, 8'h01, 32'h0000_4000},
    {1'b0, 1'b0, 1'b1, 8'hFE, 8'h1E, 8'h08, 32'h1234_5678}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Reference CRC: XOR the byte into the top, then eight shifts.
  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c;
    c = 16'h4F4E;
    for (int i = 0; i < n; i++) begin
      c = c ^ {pg[i], 8'h00};
      for (int b = 0; b < 8; b++) c = c[15] ? ((c << 1) ^ 16'h8005) : (c << 1);
    end
    return c;
  endfunction

  task automatic build(input logic [58:0] v, input int salt);
    logic [31:0] bpp, ppb, bpl;
    bpp = v[31:0];
    ppb = {bpp[15:0], bpp[31:16]};
    bpl = ~bpp;
    for (int i = 0; i < 256; i++) pg[i] = 8'((i * 7 + salt * 13) ^ (i >> 3));
    pg[0] = 8'h4F; pg[1] = 8'h4E; pg[2] = 8'h46; pg[3] = 8'h49;
    if (v[58]) pg[1] = 8'h4D;
    pg[6] = v[55:48];
    for (int k = 0; k < 4; k++) begin
      pg[80 + k] = bpp[8*k +: 8];
      pg[92 + k] = ppb[8*k +: 8];
      pg[96 + k] = bpl[8*k +: 8];
    end
    pg[100] = v[39:32];
    pg[112] = v[47:40];
    exp_crc = ref_crc(254);
    pg[254] = exp_crc[7:0];
    pg[255] = exp_crc[15:8];
    if (v[57]) pg[255] = pg[255] ^ 8'h21;
  endtask

  // Drive bytes [0, upto) from pg; inputs change on falling edges.
  task automatic stream(input int upto, input bit gaps);
    for (int i = 0; i < upto; i++) begin
      sop = (i == 0); byte_vld = 1'b1; byte_in = pg[i];
      @(negedge clk);
      sop = 1'b0; byte_vld = 1'b0;
      if (gaps && (i % 5 == 2)) begin
        byte_in = 8'hA5;
        @(negedge clk);
      end
    end
  endtask

  task automatic check_result(input logic [58:0] v);
    logic ecc_on;
    ecc_on = (v[47:40] != 8'hFF);
    check("R4",  "done",        32'(done),    32'd1);
    check("R7",  "sig_ok",      32'(sig_ok),  32'(!v[58]));
    check("R6",  "crc_ok",      32'(crc_ok),  32'(!v[57]));
    check("R8",  "page_ok",     32'(page_ok), 32'(!v[58] && !v[57]));
    check("R5",  "crc_calc",    32'(crc_calc), 32'(exp_crc));
    check("R6",  "crc_stored",  32'(crc_stored), 32'({pg[255], pg[254]}));
    check("R9",  "bus16",       32'(bus16),   32'(v[48]));
    check("R10", "page_bytes",  page_bytes,   v[31:0]);
    check("R10", "blk_pages",   blk_pages,    {v[15:0], v[31:16]});
    check("R10", "lun_blocks",  lun_blocks,   ~v[31:0]);
    check("R10", "lun_cnt",     32'(lun_cnt), 32'(v[39:32]));
    check("R11", "ecc_present", 32'(ecc_present), 32'(ecc_on));
    check("R11", "ecc_bits",    32'(ecc_bits), ecc_on ? 32'(v[47:40]) : 32'd0);
    check("R11", "ecc_step",    32'(ecc_step), ecc_on ? 32'd512 : 32'd0);
  endtask

  initial begin
    #(CLK_NS * 200000);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", "done",        32'(done),        32'd0);
    check("R1", "sig_ok",      32'(sig_ok),      32'd0);
    check("R1", "crc_ok",      32'(crc_ok),      32'd0);
    check("R1", "page_ok",     32'(page_ok),     32'd0);
    check("R1", "ecc_present", 32'(ecc_present), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: bytes before any start are ignored
    for (int i = 0; i < 300; i++) begin
      byte_vld = 1'b1; byte_in = 8'(i);
      @(negedge clk);
    end
    byte_vld = 1'b0;
    check("R3", "done before start", 32'(done), 32'd0);
    check("R3", "page_bytes before start", page_bytes, 32'd0);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      build(VEC[v], v);
      stream(255, VEC[v][56]);
      check("R4", "done before last byte", 32'(done), 32'd0);
      sop = 1'b0; byte_vld = 1'b1; byte_in = pg[255];
      @(negedge clk);
      byte_vld = 1'b0;
      check_result(VEC[v]);
    end

    // R3: stray bytes and a strobe without valid after done
    sop = 1'b1; byte_vld = 1'b0; byte_in = 8'h00;
    @(negedge clk);
    sop = 1'b0;
    for (int i = 0; i < 20; i++) begin
      byte_vld = 1'b1; byte_in = 8'hFF - 8'(i);
      @(negedge clk);
    end
    byte_vld = 1'b0;
    check("R2", "strobe without valid keeps done", 32'(done), 32'd1);
    check_result(VEC[NV-1]);

    // R2: restart in mid-page; R4: done clears after new start
    build(VEC[2], 9);
    stream(100, 1'b0);
    check("R4", "done cleared by start", 32'(done), 32'd0);
    build(VEC[0], 11);
    stream(256, 1'b0);
    check("R2", "restart page_ok", 32'(page_ok), 32'd1);
    check_result(VEC[0]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule